// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Lane Writes

This block is a synthesizable model of a small synchronous static RAM with a two-bit burst counter. Each word is four lanes of nine bits: eight data bits and one parity bit per lane. Address, strobes, chip selects, write controls and input data are captured on the rising clock edge. Writes are self-timed, so no external write pulse is needed. Read data is flow-through: it appears in the same cycle, addressed by the registered burst address.

A burst starts when the processor strobe or the controller strobe is sampled active. After that, the advance input moves through four addresses, in linear or interleaved order. The order is chosen by an unclocked mode pin. The output enable is also unclocked. A sleep input stops all activity, keeps the stored data, and then holds the block in two wake-up cycles in which strobes are refused. A strobe that arrives during those cycles raises a sticky error flag.

Top module: `sbsram_top`

## Requirements
- R1: When `gw_n` is low at an access edge, all four lanes of the accessed word are written from `din`, whatever `bwe_n` and `lane_we_n` are.
- R2: When `gw_n` is high and `bwe_n` is low, only the lanes whose bit in `lane_we_n` is low are written; lane i is `din[9i+8:9i]`, and the other lanes keep their contents.
- R3: An access is a read, and leaves memory unchanged, when `gw_n` and `bwe_n` are both high, or when `bwe_n` is low with all of `lane_we_n` high.
- R4: `adsc_n` low with all selects active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) loads `addr` as the burst start and accesses that word on the same edge, writing it if the write controls request a write.
- R5: `adsp_n` low with `cs1_n` low starts a burst whose first edge is always a read, even when write controls are active. `adsp_n` low with `cs1_n` high is ignored, so a running burst continues.
- R6: A start strobe that is sampled while any chip select is inactive deselects the block. `dout_en` then stays low until the next selected start.
- R7: At an edge with no strobe in an active burst, `adv_n` low steps the burst. The low two address bits follow (start+k) mod 4 when `burst_ilv`=0 and start XOR k when `burst_ilv`=1. The upper bits are fixed, and the counter wraps after four steps.
- R8: With `adv_n` high and no strobe, the burst stays on its current word, which is read or written according to the write controls.
- R9: After a read edge, `dout_en` is high and `dout` holds the addressed word as long as `oe_n` is low. A change on `oe_n` acts on `dout_en` with no clock edge.
- R10: While `sleep` is high, `dout_en` is low at once, no edge accesses memory, the running burst is dropped and stored data is kept.
- R11: The first two edges after `sleep` falls ignore all strobes. A strobe at either of them sets `wake_err`, which stays set until reset.
- R12: After reset, `dout_en` and `wake_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | AW | Start address of a burst |
| adsp_n | input | 1 | Processor start strobe, active low |
| adsc_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Lane write enable qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Unclocked output enable, active low |
| burst_ilv | input | 1 | Unclocked burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Power-down request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable |
| wake_err | output | 1 | Sticky flag for a strobe during wake-up |

## Verification
Every address is first filled with a whole-word write and then read back, which separates address decoding faults from lane faults. All sixteen lane-enable patterns are then written to separate words, so each lane's gating is checked both where it writes and where it holds. Bursts from all four start offsets are run in both orders, including the wrap step, and the processor strobe is given active write controls so that a wrongly taken write would show up. Further sequences cover suspend and continue writes, deselection, the unclocked output enable, accesses refused during sleep, and strobes placed on the wake-up edges.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    parameter int LANES    = 4;
    parameter int LANE_W   = 9;
    parameter int WAKE_CYC = 2;
    localparam int WAKE_W  = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic              active;
        logic              rd;
        logic [1:0]        cnt;
        logic [WAKE_W-1:0] wake;
        logic              err;
    } ctl_t;
endpackage

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq (
    input  logic [1:0] start_lo,
    input  logic [1:0] step,
    input  logic       ilv,
    output logic [1:0] lo
);
    always_comb begin
        if (ilv) lo = start_lo ^ step;
        else     lo = start_lo + step;
    end
endmodule

// File: rtl/sbsram_lane_dec.sv
module sbsram_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic [LANES-1:0] mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[g] = !gw_n || (!bwe_n && !lane_we_n[g]);
    end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en,
    output logic                    wake_err
);
    localparam int DW = LANES * LANE_W;

    ctl_t            ctl_d, ctl_q;
    logic [AW-1:0]   base_d, base_q;
    logic [1:0]      cnt_nx;
    logic [1:0]      lo_cur, lo_nx;
    logic [LANES-1:0] wr_mask;
    logic [LANES-1:0] mem_we;
    logic [AW-1:0]   acc_addr;
    logic [AW-1:0]   rd_addr;
    logic [DW-1:0]   rdata;
    logic            sel_all, p_go, c_go, strobe_any, is_wr;
    logic            wake_busy;

    sbsram_lane_dec #(.LANES(LANES)) dec_i (
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .mask(wr_mask)
    );

    assign cnt_nx = ctl_q.cnt + {1'b0, !adv_n};

    sbsram_burst_seq seq_cur_i (
        .start_lo(base_q[1:0]), .step(ctl_q.cnt), .ilv(burst_ilv), .lo(lo_cur)
    );
    sbsram_burst_seq seq_nx_i (
        .start_lo(base_q[1:0]), .step(cnt_nx), .ilv(burst_ilv), .lo(lo_nx)
    );

    assign rd_addr    = {base_q[AW-1:2], lo_cur};
    assign sel_all    = !cs1_n && cs2 && !cs3_n;
    assign p_go       = !adsp_n && !cs1_n;
    assign c_go       = !adsc_n;
    assign strobe_any = !adsp_n || !adsc_n;
    assign is_wr      = |wr_mask;
    assign wake_busy  = (ctl_q.wake != '0);

    always_comb begin
        ctl_d    = ctl_q;
        base_d   = base_q;
        acc_addr = rd_addr;
        mem_we   = '0;
        if (sleep) begin
            ctl_d.active = 1'b0;
            ctl_d.rd     = 1'b0;
            ctl_d.wake   = WAKE_W'(WAKE_CYC);
        end else if (wake_busy) begin
            ctl_d.wake = ctl_q.wake - 1'b1;
            if (strobe_any) ctl_d.err = 1'b1;
        end else if (p_go || c_go) begin
            if (sel_all) begin
                base_d       = addr;
                ctl_d.cnt    = 2'd0;
                ctl_d.active = 1'b1;
                acc_addr     = addr;
                if (!p_go && is_wr) begin
                    mem_we   = wr_mask;
                    ctl_d.rd = 1'b0;
                end else begin
                    ctl_d.rd = 1'b1;
                end
            end else begin
                ctl_d.active = 1'b0;
                ctl_d.rd     = 1'b0;
            end
        end else if (ctl_q.active) begin
            ctl_d.cnt = cnt_nx;
            acc_addr  = {base_q[AW-1:2], lo_nx};
            mem_we    = wr_mask;
            ctl_d.rd  = !is_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            base_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            base_q <= base_d;
        end
    end

    sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .we(mem_we), .waddr(acc_addr), .wdata(din),
        .raddr(rd_addr), .rdata(rdata)
    );

    assign dout_en  = !oe_n && !sleep && ctl_q.active && ctl_q.rd;
    assign dout     = dout_en ? rdata : '0;
    assign wake_err = ctl_q.err;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk (
    input logic clk,
    input logic rst_n,
    input logic adsp_n,
    input logic adsc_n,
    input logic cs1_n,
    input logic cs2,
    input logic cs3_n,
    input logic oe_n,
    input logic sleep,
    input logic dout_en,
    input logic wake_err,
    input logic wake_busy
);
    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_en);

    a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err |=> wake_err);

    a_r11_wake_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_busy && !sleep && (!adsp_n || !adsc_n)) |=> wake_err);

    a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !wake_busy && !adsc_n && (cs1_n || !cs2 || cs3_n)) |=> !dout_en);

    a_r5_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !wake_busy && !adsp_n && !cs1_n && cs2 && !cs3_n)
        |=> (dout_en == (!oe_n && !sleep)));
endmodule

bind sbsram_top sbsram_chk chk_i (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .oe_n(oe_n), .sleep(sleep),
    .dout_en(dout_en), .wake_err(wake_err), .wake_busy(wake_busy)
);

// File: tb/sbsram_top_tb_top.sv
module sbsram_top_tb_top;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic          oe_n = 1'b0, burst_ilv = 1'b0, sleep = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, wake_err;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] exp_mem [N];

    always #5 clk = ~clk;

    sbsram_top #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .lane_we_n(lane_we_n), .oe_n(oe_n), .burst_ilv(burst_ilv),
        .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en), .wake_err(wake_err)
    );

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a) * 36'h0_04C1_1DB7 + 36'h5_5AA5_F00F;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; lane_we_n = 4'hF; din = '0;
    endtask

    task automatic wr_c(int a, logic [DW-1:0] d);
        idle_in(); adsc_n = 1'b0; addr = AW'(a); gw_n = 1'b0; din = d;
        tick(); exp_mem[a] = d; idle_in();
    endtask

    task automatic rd_c(int a);
        idle_in(); adsc_n = 1'b0; addr = AW'(a);
        tick(); idle_in();
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_in();
        #23;
        chk("R12 dout_en", DW'(dout_en), '0);
        chk("R12 wake_err", DW'(wake_err), '0);
        rst_n = 1'b1;
        tick();

        // R1 R4: whole-word writes with bwe_n high and lanes off, then readback
        for (int a = 0; a < N; a++) begin
            idle_in(); adsc_n = 1'b0; addr = AW'(a); gw_n = 1'b0;
            bwe_n = 1'b1; lane_we_n = 4'hF; din = pat(a);
            tick(); exp_mem[a] = pat(a);
        end
        idle_in();
        for (int a = 0; a < N; a++) begin
            rd_c(a);
            chk("R1 R4 R9 readback", dout_en ? dout : 'x, exp_mem[a]);
        end

        // R2 R3: every lane pattern; lane_we_n = m, low bit = written lane
        for (int m = 0; m < 16; m++) begin
            idle_in(); adsc_n = 1'b0; addr = AW'(16 + m);
            bwe_n = 1'b0; lane_we_n = 4'(m); din = ~pat(m + 100);
            tick();
            for (int g = 0; g < 4; g++)
                if (!m[g]) exp_mem[16 + m][g*9 +: 9] = din[g*9 +: 9];
            rd_c(16 + m);
            chk(m == 15 ? "R3 lanes all off" : "R2 lane mask", dout, exp_mem[16 + m]);
        end

        // R3: bwe_n high with lanes low is a read
        idle_in(); adsc_n = 1'b0; addr = 6'd40; bwe_n = 1'b1; lane_we_n = 4'h0; din = '1;
        tick(); idle_in();
        chk("R3 read with lanes low", dout_en ? dout : 'x, exp_mem[40]);

        // R5 R7: bursts, all starts, both orders, with write controls active at start
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int s = 0; s < 4; s++) begin
                burst_ilv = ilv[0];
                idle_in(); adsp_n = 1'b0; addr = AW'(32 + s);
                gw_n = 1'b0; bwe_n = 1'b0; lane_we_n = 4'h0; din = '1;
                tick(); idle_in();
                chk("R5 first edge read", dout_en ? dout : 'x, exp_mem[32 + s]);
                for (int k = 1; k <= 4; k++) begin
                    int lo;
                    adv_n = 1'b0;
                    tick();
                    lo = ilv ? (s ^ (k % 4)) : ((s + k) % 4);
                    chk("R7 burst order", dout_en ? dout : 'x, exp_mem[32 + lo]);
                end
                idle_in();
            end
        end
        burst_ilv = 1'b0;

        // R5: processor strobe with cs1_n high is ignored; burst steps
        rd_c(44);
        adsp_n = 1'b0; cs1_n = 1'b1; addr = 6'd8; adv_n = 1'b0;
        tick(); idle_in();
        chk("R5 blocked strobe", dout_en ? dout : 'x, exp_mem[45]);

        // R8: suspend write, suspend read, continue write
        rd_c(20);
        gw_n = 1'b0; din = 36'hA_BCDE_1234; adv_n = 1'b1;
        tick(); exp_mem[20] = 36'hA_BCDE_1234; idle_in();
        chk("R8 write drops drive", DW'(dout_en), '0);
        tick();
        chk("R8 suspend read", dout_en ? dout : 'x, exp_mem[20]);
        gw_n = 1'b0; din = 36'h1_2345_6789; adv_n = 1'b0;
        tick(); exp_mem[21] = 36'h1_2345_6789; idle_in();
        tick();
        chk("R8 continue write", dout_en ? dout : 'x, exp_mem[21]);

        // R6: deselect by cs2 low, then by cs3_n high on processor strobe
        rd_c(3);
        adsc_n = 1'b0; cs2 = 1'b0; addr = 6'd4;
        tick(); idle_in();
        chk("R6 cs2 deselect", DW'(dout_en), '0);
        adv_n = 1'b0;
        tick(); idle_in();
        chk("R6 stays deselected", DW'(dout_en), '0);
        rd_c(3);
        adsp_n = 1'b0; cs3_n = 1'b1;
        tick(); idle_in();
        chk("R6 cs3 deselect", DW'(dout_en), '0);

        // R9: output enable acts with no clock edge
        rd_c(10);
        oe_n = 1'b1; #1;
        chk("R9 oe off", DW'(dout_en), '0);
        oe_n = 1'b0; #1;
        chk("R9 oe on", dout_en ? dout : 'x, exp_mem[10]);

        // R10: sleep drops drive, blocks writes, keeps data
        sleep = 1'b1; #1;
        chk("R10 sleep drive", DW'(dout_en), '0);
        for (int i = 0; i < 3; i++) begin
            adsc_n = 1'b0; gw_n = 1'b0; addr = 6'd5; din = '0;
            tick();
        end
        idle_in(); sleep = 1'b0;
        tick(); tick();
        chk("R11 clean wake", DW'(wake_err), '0);
        rd_c(5);
        chk("R10 data kept", dout_en ? dout : 'x, exp_mem[5]);

        // R11: strobe on first wake edge is refused and flagged
        sleep = 1'b1; tick(); sleep = 1'b0;
        adsc_n = 1'b0; gw_n = 1'b0; addr = 6'd6; din = '0;
        tick(); idle_in();
        chk("R11 flag set", DW'(wake_err), 1);
        adsp_n = 1'b0; addr = 6'd7;
        tick(); idle_in();
        chk("R11 second wake edge refused", DW'(dout_en), '0);
        rd_c(6);
        chk("R11 write refused", dout_en ? dout : 'x, exp_mem[6]);
        tick(); tick();
        chk("R11 flag sticky", DW'(wake_err), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule